// File: doc/BRIEF.md
# PCI Master Write Burst Controller

This block moves buffered write commands onto a PCI bus as master. A command (start address, address space and data-phase count) is taken from the request side. The write data sits in a separate FIFO, which the block sees through its fill level and a pop strobe. The block waits until enough data is buffered. It then requests the bus from an arbiter, drives one address phase and bursts data phases until something ends the transaction. Each command becomes its own transaction or transactions. Commands are never joined, even when their addresses follow on from each other.

The cause of every transaction end is sorted, and each cause has its own recovery:
- The final phase completes the command.
- Latency-timer expiry, target disconnect and target retry re-request the bus and resume at the first address not yet written, with the count reduced.
- A buffer underrun releases the bus and waits for a refill threshold before it resumes.
- A target-abort or master-abort sets a sticky write-failure flag and drains the rest of the command's data from the FIFO without driving the bus.

The bus handshake is simplified. FRAME# stays low for the address phase and every data phase of a transaction. FRAME# and IRDY# return high together in the cycle after the terminating clock. Parity, electrical timing and reads are not modelled.

FSM states: IDLE (ready for a command), FILL (waiting for the buffer threshold), REQ (arbiter request), ADDR (address phase), DATA (data phases), FLUSH (discarding after an abort). The transitions are:
- IDLE to FILL: command accepted.
- FILL to REQ: threshold met.
- REQ to ADDR: grant.
- ADDR to DATA: always, after one cycle.
- DATA to IDLE: last phase.
- DATA to REQ: disconnect, retry or latency expiry.
- DATA to FILL: no data for the next phase.
- DATA to FLUSH: either abort.
- FLUSH to IDLE: remaining count drained.

Top module: `pci_wr_burst_ctl`

## Requirements
- R1: A command is accepted only while `cmd_ready` is high, which is only in IDLE, and `cmd_len` must be non-zero. Every accepted command gets its own arbitration and address phase. The address phase drives the current address on `pci_ad` and the command code on `pci_cbe_n`: space 0 gives 4'b1011 (configuration write), space 1 gives 4'b0011 (I/O write), spaces 2 and 3 give 4'b0111 (memory write).
- R2: The arbiter is not requested (FILL state) until `fifo_level` reaches the threshold or the remaining command size. The level is counted in DWORDs. The threshold is 8 DWORDs for a 32-bit bus and 16 DWORDs for a 64-bit bus. The remaining size is the remaining phases times DATA_W/32.
- R3: In DATA, IRDY# is low whenever at least one phase of data is buffered. A data phase counts only on a clock with IRDY# and TRDY# both low. That clock pops the FIFO, and `pci_ad` carries the FIFO head.
- R4: On the clock that completes the final counted phase, the transaction ends and `cmd_done` pulses high for one cycle in the following cycle. The block then returns to IDLE.
- R5: If `lat_expired` is high in a data cycle, the transaction ends after that cycle and the bus is requested again. The next address phase is at the start address plus 4·(DATA_W/32) bytes per completed phase, and only the remaining phases follow.
- R6: If a data cycle finds no phase of data buffered, the transaction ends and the block returns to FILL under the rule of R2.
- R7: STOP# low with DEVSEL# low (disconnect or retry) ends the transaction and re-requests the bus. Address and count resume after the phases already transferred. A retry with no data leaves both unchanged.
- R8: STOP# low with DEVSEL# high, after DEVSEL# was seen low in this transaction, is a target-abort. It sets bit 0 of `stat_reg` and pops, without any bus activity, the command's untransferred words. `cmd_done` does not pulse.
- R9: If DEVSEL# is not low in any of the first 5 data cycles after the address phase, the result is a master-abort with the same effect as R8. DEVSEL# low in the fifth cycle is still accepted.
- R10: `stat_reg[0]` stays set until a cycle with `stat_wr` high and `stat_wdata` = 1. A write of 0 leaves it unchanged. The other bits of `stat_reg` read 0.
- R11: When nothing ends it, a burst carries all phases of a command under one address phase, with FRAME# held low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_addr | input | 32 | Start byte address |
| cmd_space | input | 2 | 0 config, 1 I/O, 2/3 memory |
| cmd_len | input | LEN_W | Data phases in the command, non-zero |
| fifo_level | input | LVL_W | Buffered DWORDs |
| fifo_data | input | DATA_W | FIFO head word |
| fifo_pop | output | 1 | Remove FIFO head |
| arb_req | output | 1 | Bus request |
| arb_gnt | input | 1 | Bus grant |
| pci_frame_n | output | 1 | FRAME#, active low |
| pci_irdy_n | output | 1 | IRDY#, active low |
| pci_trdy_n | input | 1 | TRDY#, active low |
| pci_stop_n | input | 1 | STOP#, active low |
| pci_devsel_n | input | 1 | DEVSEL#, active low |
| pci_ad | output | DATA_W | Address in address phase, data in data phases |
| pci_cbe_n | output | DATA_W/8 | Command code, then byte enables (all on) |
| lat_expired | input | 1 | Latency timer has run out |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 1 | Value written toward bit 0; 1 clears |
| stat_reg | output | STAT_W | Interrupt status; bit 0 is write failure |
| cmd_done | output | 1 | One-cycle command-complete pulse |

## Verification
The hardest situation to reach is the underrun path. The buffer has to run dry in the middle of a granted burst, and it then has to refill to a level that lies between the remaining-size rule and the fixed threshold. The stimulus first parks the block in FILL one word short of the threshold. It then releases exactly eight words, so the ninth data cycle finds the FIFO empty. Finally it feeds three words, then a fourth, checking at each step that no request is raised too early. Target behaviour (DEVSEL# delay, retry, disconnect point, abort point, latency pulse) is set per scenario as a one-shot by the bench's responder model.

// File: rtl/pciwb_pkg.sv
package pciwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_FLUSH
    } wb_state_e;

    // bus command code for a write into the given address space
    function automatic logic [3:0] wr_cmd_code(input logic [1:0] space);
        logic [3:0] code;
        unique case (space)
            2'd0:    code = 4'b1011;
            2'd1:    code = 4'b0011;
            default: code = 4'b0111;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/pciwb_progress.sv
module pciwb_progress #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  rem
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            rem  <= '0;
        end else if (load) begin
            addr <= load_addr;
            rem  <= load_len;
        end else if (step) begin
            addr <= addr + ADDR_W'(STEP_BYTES);
            rem  <= rem - LEN_W'(1);
        end
    end

endmodule

// File: rtl/pciwb_devsel_watch.sv
module pciwb_devsel_watch #(
    parameter int ABORT_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    input  logic devsel_n,
    output logic seen,
    output logic expire
);

    localparam int CNT_W = $clog2(ABORT_CLKS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            if (!devsel_n)
                seen <= 1'b1;
            else if (!seen)
                cnt <= cnt + CNT_W'(1);
        end
    end

    assign expire = tick && !seen && devsel_n && (cnt == CNT_W'(ABORT_CLKS - 1));

endmodule

// File: rtl/pciwb_resume_gate.sv
module pciwb_resume_gate #(
    parameter int LVL_W        = 9,
    parameter int LEN_W        = 8,
    parameter int DW_PER_PHASE = 1,
    parameter int THRESH_DW    = 8
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LEN_W-1:0] rem,
    output logic             have_phase,
    output logic             open
);

    localparam int SUM_W = LVL_W + LEN_W + 3;

    logic [SUM_W-1:0] lvl_x;
    logic [SUM_W-1:0] need_x;

    always_comb begin
        lvl_x      = SUM_W'(level);
        need_x     = SUM_W'(rem) * SUM_W'(DW_PER_PHASE);
        have_phase = lvl_x >= SUM_W'(DW_PER_PHASE);
        open       = (lvl_x >= SUM_W'(THRESH_DW)) || (lvl_x >= need_x);
    end

endmodule

// File: rtl/pci_wr_burst_ctl.sv
module pci_wr_burst_ctl
    import pciwb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int LVL_W      = 9,
    parameter int ABORT_CLKS = 5,
    parameter int STAT_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [31:0]         cmd_addr,
    input  logic [1:0]          cmd_space,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [LVL_W-1:0]    fifo_level,
    input  logic [DATA_W-1:0]   fifo_data,
    output logic                fifo_pop,
    output logic                arb_req,
    input  logic                arb_gnt,
    output logic                pci_frame_n,
    output logic                pci_irdy_n,
    input  logic                pci_trdy_n,
    input  logic                pci_stop_n,
    input  logic                pci_devsel_n,
    output logic [DATA_W-1:0]   pci_ad,
    output logic [DATA_W/8-1:0] pci_cbe_n,
    input  logic                lat_expired,
    input  logic                stat_wr,
    input  logic                stat_wdata,
    output logic [STAT_W-1:0]   stat_reg,
    output logic                cmd_done
);

    localparam int DW_PER_PHASE = DATA_W / 32;
    localparam int THRESH_DW    = (DATA_W == 64) ? 16 : 8;
    localparam int STEP_BYTES   = DW_PER_PHASE * 4;
    localparam int CBE_W        = DATA_W / 8;

    wb_state_e        state, nxt;
    logic [1:0]       space_q;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] rem;
    logic             have_phase, gate_open;
    logic             dv_seen, m_abort;
    logic             in_data, xfer, last_xfer, t_abort, stop_cont, flush_pop;
    logic             fail_q, done_q;

    pciwb_progress #(
        .ADDR_W(32), .LEN_W(LEN_W), .STEP_BYTES(STEP_BYTES)
    ) u_prog (
        .clk(clk), .rst_n(rst_n),
        .load(state == ST_IDLE && cmd_valid),
        .load_addr(cmd_addr), .load_len(cmd_len),
        .step(fifo_pop), .addr(cur_addr), .rem(rem)
    );

    pciwb_resume_gate #(
        .LVL_W(LVL_W), .LEN_W(LEN_W), .DW_PER_PHASE(DW_PER_PHASE), .THRESH_DW(THRESH_DW)
    ) u_gate (
        .level(fifo_level), .rem(rem), .have_phase(have_phase), .open(gate_open)
    );

    pciwb_devsel_watch #(
        .ABORT_CLKS(ABORT_CLKS)
    ) u_watch (
        .clk(clk), .rst_n(rst_n), .arm(state == ST_ADDR), .tick(in_data),
        .devsel_n(pci_devsel_n), .seen(dv_seen), .expire(m_abort)
    );

    // termination classification
    always_comb begin
        in_data   = (state == ST_DATA);
        xfer      = in_data && have_phase && !pci_trdy_n;
        last_xfer = xfer && (rem == LEN_W'(1));
        t_abort   = in_data && !pci_stop_n && pci_devsel_n && dv_seen;
        stop_cont = in_data && !pci_stop_n && !pci_devsel_n;
        flush_pop = (state == ST_FLUSH) && have_phase && (rem != '0);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) nxt = ST_FILL;
            ST_FILL:  if (gate_open) nxt = ST_REQ;
            ST_REQ:   if (arb_gnt)   nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_DATA;
            ST_DATA: begin
                if (m_abort || t_abort)           nxt = ST_FLUSH;
                else if (last_xfer)               nxt = ST_IDLE;
                else if (stop_cont || lat_expired) nxt = ST_REQ;
                else if (!have_phase)             nxt = ST_FILL;
            end
            ST_FLUSH: if (rem == '0 || (flush_pop && rem == LEN_W'(1))) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and registered side results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            space_q <= '0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= last_xfer && !m_abort && !t_abort;
            if (state == ST_IDLE && cmd_valid)
                space_q <= cmd_space;
            if (m_abort || t_abort)
                fail_q <= 1'b1;
            else if (stat_wr && stat_wdata)
                fail_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cmd_ready   = (state == ST_IDLE);
        arb_req     = (state == ST_REQ);
        pci_frame_n = !(state == ST_ADDR || in_data);
        pci_irdy_n  = !(in_data && have_phase);
        fifo_pop    = xfer || flush_pop;
        cmd_done    = done_q;
        stat_reg    = STAT_W'(fail_q);
        if (state == ST_ADDR) begin
            pci_ad    = DATA_W'(cur_addr);
            pci_cbe_n = CBE_W'(wr_cmd_code(space_q));
        end else begin
            pci_ad    = in_data ? fifo_data : '0;
            pci_cbe_n = '0;
        end
    end

endmodule

// File: rtl/pciwb_chk.sv
module pciwb_chk #(
    parameter int LEN_W  = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              fifo_pop,
    input logic              arb_req,
    input logic              pci_frame_n,
    input logic              pci_irdy_n,
    input logic              pci_trdy_n,
    input logic              stat_wr,
    input logic              stat_wdata,
    input logic [STAT_W-1:0] stat_reg,
    input logic              cmd_done
);

    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |-> (cmd_len != '0));

    a_r1_idle_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (pci_frame_n && !arb_req));

    a_r3_pop_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !pci_frame_n) |-> (!pci_irdy_n && !pci_trdy_n));

    a_r3_irdy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_irdy_n |-> !pci_frame_n);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r5_req_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> pci_frame_n);

    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_reg[0] && !(stat_wr && stat_wdata)) |=> stat_reg[0]);

endmodule

bind pci_wr_burst_ctl pciwb_chk #(.LEN_W(LEN_W), .STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .fifo_pop(fifo_pop), .arb_req(arb_req),
    .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_reg(stat_reg), .cmd_done(cmd_done)
);

// File: tb/pci_wr_burst_ctl_tb.sv
module pci_wr_burst_ctl_tb;

    localparam int LEN_W = 8;
    localparam int LVL_W = 9;

    typedef enum int {M_NORM, M_RETRY, M_DISC, M_TABT, M_LAT} tmode_e;
    typedef struct {
        bit          is_addr;
        logic [31:0] v;
        logic [3:0]  c;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [1:0] cmd_space = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [LVL_W-1:0] fifo_level;
    logic [31:0] fifo_data;
    logic fifo_pop, arb_req;
    logic arb_gnt = 1'b0;
    logic pci_frame_n, pci_irdy_n;
    logic pci_trdy_n = 1'b1, pci_stop_n = 1'b1, pci_devsel_n = 1'b1;
    logic [31:0] pci_ad;
    logic [3:0] pci_cbe_n;
    logic lat_expired = 1'b0;
    logic stat_wr = 1'b0, stat_wdata = 1'b0;
    logic [7:0] stat_reg;
    logic cmd_done;

    int total = 0, bad = 0, wd = 0, done_cnt = 0;
    logic [31:0] mem [256];
    int wrp = 0, rdp = 0;
    bit pop_pend = 0;
    item_t sb[$];
    string cur_tag = "R1";
    tmode_e t_mode = M_NORM;
    int t_k = 0, t_dly = 1, cyc = 0, nx = 0;
    bit in_txn = 0, frame_prev = 1;

    always #2.5 clk = ~clk;

    assign fifo_level = LVL_W'(wrp - rdp);
    assign fifo_data  = mem[rdp % 256];

    pci_wr_burst_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_space(cmd_space), .cmd_len(cmd_len),
        .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .arb_req(arb_req), .arb_gnt(arb_gnt), .pci_frame_n(pci_frame_n),
        .pci_irdy_n(pci_irdy_n), .pci_trdy_n(pci_trdy_n), .pci_stop_n(pci_stop_n),
        .pci_devsel_n(pci_devsel_n), .pci_ad(pci_ad), .pci_cbe_n(pci_cbe_n),
        .lat_expired(lat_expired), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_reg(stat_reg), .cmd_done(cmd_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // target responder, arbiter, FIFO model and scoreboard monitor
    always @(negedge clk) begin
        bit dv;
        item_t it;
        if (pop_pend) begin rdp++; pop_pend = 0; end
        lat_expired = 1'b0;
        if (pci_frame_n) begin
            in_txn = 0; pci_devsel_n = 1; pci_trdy_n = 1; pci_stop_n = 1;
        end else if (!in_txn) begin
            in_txn = 1; cyc = 0; nx = 0;
            pci_devsel_n = 1; pci_trdy_n = 1; pci_stop_n = 1;
        end else begin
            cyc++;
            dv = (cyc >= t_dly);
            pci_devsel_n = !dv; pci_trdy_n = !dv; pci_stop_n = 1;
            case (t_mode)
                M_RETRY: if (dv) begin pci_trdy_n = 1; pci_stop_n = 0; t_mode = M_NORM; end
                M_DISC:  if (dv && nx == t_k - 1) begin pci_stop_n = 0; t_mode = M_NORM; end
                M_TABT:  if (nx == t_k) begin pci_devsel_n = 1; pci_trdy_n = 1; pci_stop_n = 0; t_mode = M_NORM; end
                M_LAT:   if (dv && nx == t_k) begin lat_expired = 1'b1; t_mode = M_NORM; end
                default: ;
            endcase
        end
        arb_gnt = arb_req;
        #1;
        if (!pci_frame_n && frame_prev) begin
            if (sb.size() == 0) chk(0, {cur_tag, " unexpected address phase"}, pci_ad, 32'hx);
            else begin
                it = sb.pop_front();
                chk(it.is_addr && pci_ad == it.v && pci_cbe_n == it.c,
                    {cur_tag, " address phase"}, {pci_ad[27:0], pci_cbe_n}, {it.v[27:0], it.c});
            end
        end
        if (!pci_frame_n && !pci_irdy_n && !pci_trdy_n) begin
            nx++;
            if (sb.size() == 0) chk(0, {cur_tag, " unexpected data phase"}, pci_ad, 32'hx);
            else begin
                it = sb.pop_front();
                chk(!it.is_addr && pci_ad == it.v, {cur_tag, " data phase R3"}, pci_ad, it.v);
            end
        end
        if (fifo_pop) pop_pend = 1;
        if (cmd_done) done_cnt++;
        frame_prev = pci_frame_n;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=<100000", wd);
            summary();
            $finish;
        end
    end

    task automatic push_words(input int n, input logic [31:0] base);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            mem[wrp % 256] = base + 32'(i);
            wrp++;
        end
    endtask

    task automatic exp_a(input logic [31:0] a, input logic [3:0] c);
        item_t it;
        it.is_addr = 1; it.v = a; it.c = c;
        sb.push_back(it);
    endtask

    task automatic exp_d(input int n, input logic [31:0] base);
        item_t it;
        for (int i = 0; i < n; i++) begin
            it.is_addr = 0; it.v = base + 32'(i); it.c = 4'h0;
            sb.push_back(it);
        end
    endtask

    task automatic send_cmd(input logic [31:0] a, input logic [1:0] sp, input int len);
        @(negedge clk);
        cmd_valid = 1; cmd_addr = a; cmd_space = sp; cmd_len = LEN_W'(len);
        forever begin
            #2;
            if (cmd_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            #2;
        end while (!cmd_ready || pop_pend);
        repeat (2) @(negedge clk);
        #2;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic stat_write(input logic v);
        @(negedge clk);
        stat_wr = 1; stat_wdata = v;
        @(negedge clk);
        stat_wr = 0; stat_wdata = 0;
        #2;
    endtask

    initial begin
        int d0;
        repeat (4) @(negedge clk);
        #2;
        chk(cmd_ready && pci_frame_n && pci_irdy_n && !arb_req && !fifo_pop,
            "R1 reset outputs", {cmd_ready, pci_frame_n, pci_irdy_n, arb_req}, 4'b1110);
        chk(stat_reg == 8'h00, "R10 reset status", stat_reg, 0);
        @(negedge clk);
        rst_n = 1;

        // R11: uninterrupted memory burst, one address phase
        cur_tag = "R11";
        push_words(4, 32'hA000_0000);
        exp_a(32'h1000, 4'b0111); exp_d(4, 32'hA000_0000);
        send_cmd(32'h1000, 2'd2, 4);
        wait_idle();
        chk(done_cnt == 1, "R4 done pulses", done_cnt, 1);
        chk(sb.size() == 0, "R11 all phases seen", sb.size(), 0);

        // R1: adjacent commands stay separate; I/O code
        cur_tag = "R1";
        push_words(4, 32'hB000_0000);
        exp_a(32'h2000, 4'b0111); exp_d(2, 32'hB000_0000);
        exp_a(32'h2008, 4'b0011); exp_d(2, 32'hB000_0002);
        send_cmd(32'h2000, 2'd3, 2);
        send_cmd(32'h2008, 2'd1, 2);
        wait_idle();
        chk(done_cnt == 3, "R1 R4 one done per command", done_cnt, 3);
        chk(sb.size() == 0, "R1 separate transactions", sb.size(), 0);

        // R9 boundary: DEVSEL# in fifth cycle is accepted; config code
        cur_tag = "R9";
        t_dly = 5;
        push_words(1, 32'hC000_0000);
        exp_a(32'h3000, 4'b1011); exp_d(1, 32'hC000_0000);
        send_cmd(32'h3000, 2'd0, 1);
        wait_idle();
        t_dly = 1;
        chk(stat_reg[0] == 1'b0, "R9 late devsel no abort", stat_reg, 0);
        chk(sb.size() == 0 && done_cnt == 4, "R9 late devsel completes", done_cnt, 4);

        // R7: disconnect with data after third phase
        cur_tag = "R7";
        t_mode = M_DISC; t_k = 3;
        push_words(6, 32'hD000_0000);
        exp_a(32'h4000, 4'b0111); exp_d(3, 32'hD000_0000);
        exp_a(32'h400C, 4'b0111); exp_d(3, 32'hD000_0003);
        send_cmd(32'h4000, 2'd2, 6);
        wait_idle();
        chk(sb.size() == 0 && done_cnt == 5, "R7 disconnect resumes", done_cnt, 5);

        // R7: retry with no data repeats the same address
        t_mode = M_RETRY;
        push_words(2, 32'hE000_0000);
        exp_a(32'h5000, 4'b0111); exp_a(32'h5000, 4'b0111); exp_d(2, 32'hE000_0000);
        send_cmd(32'h5000, 2'd2, 2);
        wait_idle();
        chk(sb.size() == 0 && done_cnt == 6, "R7 retry resumes", done_cnt, 6);

        // R5: latency expiry during third phase
        cur_tag = "R5";
        t_mode = M_LAT; t_k = 2;
        push_words(5, 32'hF000_0000);
        exp_a(32'h6000, 4'b0111); exp_d(3, 32'hF000_0000);
        exp_a(32'h600C, 4'b0111); exp_d(2, 32'hF000_0003);
        send_cmd(32'h6000, 2'd2, 5);
        wait_idle();
        chk(sb.size() == 0 && done_cnt == 7, "R5 latency continuation", done_cnt, 7);

        // R2 / R6: threshold gate and underrun
        cur_tag = "R6";
        push_words(7, 32'h1100_0000);
        push_words(1, 32'h1100_0007);
        rdp = rdp; // keep ordering explicit
        wrp = wrp - 1; // hold back the eighth word
        exp_a(32'h7000, 4'b0111); exp_d(8, 32'h1100_0000);
        exp_a(32'h7020, 4'b0111); exp_d(4, 32'h1100_0008);
        send_cmd(32'h7000, 2'd2, 12);
        wait_cyc(10);
        chk(!arb_req && pci_frame_n, "R2 no request below threshold", arb_req, 0);
        push_words(1, 32'h1100_0007);
        do wait_cyc(1); while (fifo_level != 0);
        wait_cyc(6);
        chk(!arb_req && pci_frame_n && !cmd_ready, "R6 waits after underrun", arb_req, 0);
        chk(sb.size() == 5, "R6 first burst length", sb.size(), 5);
        push_words(3, 32'h1100_0008);
        wait_cyc(10);
        chk(!arb_req && pci_frame_n, "R2 three of four words", arb_req, 0);
        push_words(1, 32'h1100_000B);
        wait_idle();
        chk(sb.size() == 0 && done_cnt == 8, "R6 resumed to completion", done_cnt, 8);

        // R8: target abort after two phases
        cur_tag = "R8";
        t_mode = M_TABT; t_k = 2;
        push_words(6, 32'h2200_0000);
        exp_a(32'h8000, 4'b0111); exp_d(2, 32'h2200_0000);
        send_cmd(32'h8000, 2'd2, 6);
        wait_idle();
        chk(stat_reg == 8'h01, "R8 failure flag", stat_reg, 1);
        chk(fifo_level == 0, "R8 remainder discarded", fifo_level, 0);
        chk(sb.size() == 0 && done_cnt == 8, "R8 no completion", done_cnt, 8);

        // R10: write 0 keeps, write 1 clears
        stat_write(1'b0);
        chk(stat_reg == 8'h01, "R10 write zero keeps flag", stat_reg, 1);
        stat_write(1'b1);
        chk(stat_reg == 8'h00, "R10 write one clears flag", stat_reg, 0);

        // R9: no DEVSEL# at all
        cur_tag = "R9";
        t_dly = 99;
        push_words(3, 32'h3300_0000);
        exp_a(32'h9000, 4'b0111);
        d0 = done_cnt;
        send_cmd(32'h9000, 2'd2, 3);
        wait_idle();
        t_dly = 1;
        chk(stat_reg == 8'h01, "R9 master abort flag", stat_reg, 1);
        chk(fifo_level == 0 && done_cnt == d0, "R9 data flushed", fifo_level, 0);
        chk(sb.size() == 0, "R9 no data phases", sb.size(), 0);

        summary();
        $finish;
    end

endmodule